// File: doc/BRIEF.md
# Cascade ID Steering for Interrupt Controllers

This block lets several interrupt controllers share one processor interrupt line as a master and up to eight slaves. With three ID bits, the system has 8 x 8 = 64 request levels. The block handles the three cascade lines, the role of the controller and the enable for driving its vector. It does not resolve priority. A resolver supplies the winning input number and the vector to present.

In master role, the block checks a per-input map that marks which inputs have a slave attached. If the winning input has a slave, the block drives that input number onto the cascade lines for the whole acknowledge sequence and stays off the data bus. Otherwise it supplies its own vector. In slave role, the cascade lines are inputs. The block compares them with its programmed ID and drives its vector only when they match.

An acknowledge sequence is one or two pulses on `ack_i`, sampled on the clock. In two-pulse mode the ID is broadcast from the first pulse and the vector goes out on the second. In one-pulse mode both happen in the single pulse.

Top module: `cas_steer`

## Requirements
- R1: In slave role `cas_oe_o` stays 0 and `cas_o` stays 0. Only a master enables the cascade outputs.
- R2: A master whose latched winner `w` has `slave_map_i[w]`=1 sets `cas_oe_o`=1 and `cas_o`=`w` from the first cycle after the first pulse is sampled until the sequence ends. It never drives data.
- R3: A master whose winner has its map bit at 0 keeps `cas_oe_o`=0 and drives `vec_i` on `data_o` with `data_oe_o`=1 during the vector pulse.
- R4: With `two_pulse_i`=1 the vector pulse is the second pulse. No data is driven during the first pulse or the gap between pulses.
- R5: With `two_pulse_i`=0 the single pulse is the vector pulse, and the sequence ends when it falls.
- R6: A slave in two-pulse mode compares `cas_i` with `own_id_i` on the edge where the first pulse is first seen low. It drives `vec_i` in the second pulse only on a match. Later changes of `cas_i` have no effect.
- R7: A slave in one-pulse mode compares `cas_i` with `own_id_i` live. `data_oe_o` follows the match within the same cycle while the pulse lasts.
- R8: Outside a sequence, and after reset, all of `cas_o`, `cas_oe_o`, `data_o` and `data_oe_o` are 0.
- R9: Role, pulse mode, winner ID and map bit are latched when the first pulse is sampled in idle. Changing them mid-sequence has no effect.
- R10: `data_o` is 0 whenever `data_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| is_master_i | input | 1 | 1 = master role, 0 = slave role |
| two_pulse_i | input | 1 | 1 = two-pulse acknowledge, 0 = one pulse |
| own_id_i | input | ID_W | ID programmed into this slave |
| slave_map_i | input | 2**ID_W | Master inputs that have a slave attached |
| win_id_i | input | ID_W | Winning input number from the resolver |
| vec_i | input | VEC_W | Vector this controller would supply |
| ack_i | input | 1 | Acknowledge pulse level |
| cas_i | input | ID_W | Cascade lines as seen by a slave |
| cas_o | output | ID_W | Cascade ID driven by a master |
| cas_oe_o | output | 1 | Output enable of the cascade lines |
| data_o | output | VEC_W | Vector to the data bus |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
Two things can fall in the same cycle in one-pulse slave mode: the ID comparison and the vector drive. The bench changes `cas_i` in the middle of a pulse and checks that `data_oe_o` drops before the next edge (R7). In two-pulse mode the comparison must not be live. To test this, the bench moves `cas_i` onto or off the slave's ID during the gap and the second pulse, and checks that the decision taken at the end of the first pulse still holds (R6). The bench also changes role and winner mid-sequence to show that the latched values govern (R9).

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_GAP    = 2'd2,
    PH_SECOND = 2'd3
  } ack_ph_e;
endpackage

// File: rtl/cas_ack_seq.sv
module cas_ack_seq
  import cas_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ack_i,
  input  logic    two_pulse_i,
  input  logic    is_master_i,
  output ack_ph_e ph_o,
  output logic    two_q_o,
  output logic    master_q_o,
  output logic    start_o,
  output logic    end_first_o,
  output logic    busy_o,
  output logic    vec_phase_o
);
  ack_ph_e ph_q, ph_d;

  assign start_o     = (ph_q == PH_IDLE) && ack_i;
  assign end_first_o = (ph_q == PH_FIRST) && !ack_i;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:   if (ack_i)  ph_d = PH_FIRST;
      PH_FIRST:  if (!ack_i) ph_d = two_q_o ? PH_GAP : PH_IDLE;
      PH_GAP:    if (ack_i)  ph_d = PH_SECOND;
      PH_SECOND: if (!ack_i) ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      two_q_o    <= 1'b0;
      master_q_o <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (start_o) begin
        two_q_o    <= two_pulse_i;
        master_q_o <= is_master_i;
      end
    end
  end

  assign ph_o        = ph_q;
  assign busy_o      = (ph_q != PH_IDLE);
  assign vec_phase_o = (ph_q == PH_SECOND) || ((ph_q == PH_FIRST) && !two_q_o);

  // R4: second pulse only reachable through the gap
  a_r4_second_after_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SECOND) |-> ($past(ph_q) == PH_GAP || $past(ph_q) == PH_SECOND));

  // R5: one-pulse sequences never enter the gap
  a_r5_no_gap_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_FIRST && !two_q_o && !ack_i) |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/cas_master_drv.sv
module cas_master_drv #(
  parameter int ID_W = 3,
  localparam int N_IR = 1 << ID_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [ID_W-1:0] win_id_i,
  input  logic [N_IR-1:0] slave_map_i,
  input  logic            master_q_i,
  input  logic            busy_i,
  output logic [ID_W-1:0] cas_o,
  output logic            cas_oe_o,
  output logic            casc_o
);
  logic [ID_W-1:0] id_q;
  logic            casc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q   <= '0;
      casc_q <= 1'b0;
    end else if (start_i) begin
      id_q   <= win_id_i;
      casc_q <= slave_map_i[win_id_i];
    end
  end

  assign casc_o   = casc_q;
  assign cas_oe_o = busy_i && master_q_i && casc_q;
  assign cas_o    = cas_oe_o ? id_q : '0;

  // R2: broadcast ID holds for the whole sequence
  a_r2_id_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_oe_o && $past(cas_oe_o)) |-> $stable(cas_o));
endmodule

// File: rtl/cas_slave_match.sv
module cas_slave_match #(
  parameter int ID_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] cas_i,
  input  logic [ID_W-1:0] own_id_i,
  input  logic            start_i,
  input  logic            end_first_i,
  input  logic            two_q_i,
  output logic            sel_o
);
  logic match_q;
  logic live_hit;

  assign live_hit = (cas_i == own_id_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          match_q <= 1'b0;
    else if (start_i)     match_q <= 1'b0;
    else if (end_first_i) match_q <= live_hit;
  end

  assign sel_o = two_q_i ? match_q : live_hit;

  // R6: latched decision frozen between the two pulses
  a_r6_match_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !end_first_i) |=> $stable(match_q));
endmodule

// File: rtl/cas_steer.sv
module cas_steer
  import cas_pkg::*;
#(
  parameter int ID_W  = 3,
  parameter int VEC_W = 8,
  localparam int N_IR = 1 << ID_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             is_master_i,
  input  logic             two_pulse_i,
  input  logic [ID_W-1:0]  own_id_i,
  input  logic [N_IR-1:0]  slave_map_i,
  input  logic [ID_W-1:0]  win_id_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             ack_i,
  input  logic [ID_W-1:0]  cas_i,
  output logic [ID_W-1:0]  cas_o,
  output logic             cas_oe_o,
  output logic [VEC_W-1:0] data_o,
  output logic             data_oe_o
);
  ack_ph_e ph;
  logic two_q, master_q, start, end_first, busy, vec_phase;
  logic casc, slave_sel;

  cas_ack_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_i       (ack_i),
    .two_pulse_i (two_pulse_i),
    .is_master_i (is_master_i),
    .ph_o        (ph),
    .two_q_o     (two_q),
    .master_q_o  (master_q),
    .start_o     (start),
    .end_first_o (end_first),
    .busy_o      (busy),
    .vec_phase_o (vec_phase)
  );

  cas_master_drv #(.ID_W(ID_W)) u_mst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .win_id_i    (win_id_i),
    .slave_map_i (slave_map_i),
    .master_q_i  (master_q),
    .busy_i      (busy),
    .cas_o       (cas_o),
    .cas_oe_o    (cas_oe_o),
    .casc_o      (casc)
  );

  cas_slave_match #(.ID_W(ID_W)) u_slv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cas_i       (cas_i),
    .own_id_i    (own_id_i),
    .start_i     (start),
    .end_first_i (end_first),
    .two_q_i     (two_q),
    .sel_o       (slave_sel)
  );

  assign data_oe_o = vec_phase && (master_q ? !casc : slave_sel);
  assign data_o    = data_oe_o ? vec_i : '0;

  // R2/R3: cascade broadcast and local vector are exclusive
  a_r3_cas_data_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_oe_o |-> !data_oe_o);

  // R8: quiet outside a sequence
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == PH_IDLE) |-> (!cas_oe_o && !data_oe_o && cas_o == '0 && data_o == '0));

  // R4: nothing on the bus during the first pulse in two-pulse mode
  a_r4_first_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (two_q && (ph == PH_FIRST || ph == PH_GAP)) |-> !data_oe_o);

  // R10: bus value zero when not driving
  a_r10_data_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));
endmodule

// File: tb/cas_steer_bench.sv
module cas_steer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 3;
  localparam int VEC_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b0, two_pulse = 1'b0, ack = 1'b0;
  logic [ID_W-1:0] own_id = '0, win_id = '0, cas_in = '0;
  logic [7:0] slave_map = '0;
  logic [VEC_W-1:0] vec = '0;
  logic [ID_W-1:0] cas_out;
  logic cas_oe, data_oe;
  logic [VEC_W-1:0] data_out;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cas_steer #(.ID_W(ID_W), .VEC_W(VEC_W)) u_cas_steer (
    .clk_i(clk), .rst_ni(rst_n), .is_master_i(is_master), .two_pulse_i(two_pulse),
    .own_id_i(own_id), .slave_map_i(slave_map), .win_id_i(win_id), .vec_i(vec),
    .ack_i(ack), .cas_i(cas_in), .cas_o(cas_out), .cas_oe_o(cas_oe),
    .data_o(data_out), .data_oe_o(data_oe)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic e_coe, logic [ID_W-1:0] e_cas,
                       logic e_doe, logic [VEC_W-1:0] e_dat);
    n_chk++;
    if (cas_oe !== e_coe || cas_out !== e_cas || data_oe !== e_doe || data_out !== e_dat) begin
      n_err++;
      $display("FAIL %s: got cas_oe=%b cas=%0d data_oe=%b data=%h, expected cas_oe=%b cas=%0d data_oe=%b data=%h",
               req, cas_oe, cas_out, data_oe, data_out, e_coe, e_cas, e_doe, e_dat);
    end
  endtask

  // R8 reset state
  task automatic t_reset();
    check("R8 reset", 0, 0, 0, 0);
  endtask

  // R2, R4: master, cascaded winner, two pulses
  task automatic t_master_casc_two();
    is_master = 1; two_pulse = 1; slave_map = 8'h24; win_id = 5; vec = 8'hA5;
    ack = 1; tick(); check("R2 first pulse", 1, 5, 0, 0);
    tick(); check("R2 first pulse held", 1, 5, 0, 0);
    ack = 0; tick(); check("R2 gap", 1, 5, 0, 0);
    ack = 1; tick(); check("R2 second pulse", 1, 5, 0, 0);
    ack = 0; tick(); check("R8 after master sequence", 0, 0, 0, 0);
  endtask

  // R3, R4: master, own vector, two pulses
  task automatic t_master_own_two();
    is_master = 1; two_pulse = 1; slave_map = 8'h24; win_id = 3; vec = 8'h3C;
    ack = 1; tick(); check("R4 no data on first pulse", 0, 0, 0, 0);
    ack = 0; tick(); check("R4 no data in gap", 0, 0, 0, 0);
    ack = 1; tick(); check("R3 own vector second pulse", 0, 0, 1, 8'h3C);
    ack = 0; tick(); check("R10 idle data zero", 0, 0, 0, 0);
  endtask

  // R5: one pulse, both cascaded and local
  task automatic t_master_single();
    is_master = 1; two_pulse = 0; slave_map = 8'h24; win_id = 2; vec = 8'h11;
    ack = 1; tick(); check("R5 single cascaded", 1, 2, 0, 0);
    ack = 0; tick(); check("R5 single ends on fall", 0, 0, 0, 0);
    win_id = 7; vec = 8'h77;
    ack = 1; tick(); check("R5 single local vector", 0, 0, 1, 8'h77);
    ack = 0; tick(); check("R5 single local ends", 0, 0, 0, 0);
  endtask

  // R6, R1: slave two pulses
  task automatic t_slave_two();
    is_master = 0; two_pulse = 1; own_id = 5; vec = 8'h5A; slave_map = 8'hFF; win_id = 5;
    cas_in = 5;
    ack = 1; tick(); check("R1 slave never drives cas", 0, 0, 0, 0);
    ack = 0; tick(); cas_in = 1;
    check("R6 gap silent", 0, 0, 0, 0);
    ack = 1; tick(); check("R6 matched slave drives on second", 0, 0, 1, 8'h5A);
    ack = 0; tick();
    cas_in = 4;
    ack = 1; tick(); ack = 0; tick(); cas_in = 5;
    ack = 1; tick(); check("R6 mismatch ignores later cas change", 0, 0, 0, 0);
    ack = 0; tick(); check("R8 slave idle", 0, 0, 0, 0);
  endtask

  // R7: slave one pulse live compare
  task automatic t_slave_single();
    is_master = 0; two_pulse = 0; own_id = 6; vec = 8'h66; cas_in = 6;
    ack = 1; tick(); check("R7 live match", 0, 0, 1, 8'h66);
    cas_in = 1; #1; check("R7 live mismatch same cycle", 0, 0, 0, 0);
    cas_in = 6; #1; check("R7 live rematch", 0, 0, 1, 8'h66);
    ack = 0; tick(); check("R7 ends", 0, 0, 0, 0);
  endtask

  // R9: role, mode, winner latched
  task automatic t_latched();
    is_master = 1; two_pulse = 1; slave_map = 8'h02; win_id = 1; vec = 8'h99;
    ack = 1; tick();
    is_master = 0; win_id = 4; two_pulse = 0; slave_map = 8'h00;
    check("R9 latched first", 1, 1, 0, 0);
    ack = 0; tick(); check("R9 latched gap", 1, 1, 0, 0);
    ack = 1; tick(); check("R9 latched second", 1, 1, 0, 0);
    ack = 0; tick(); check("R9 ends", 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_master_casc_two();
    t_master_own_two();
    t_master_single();
    t_slave_two();
    t_slave_single();
    t_latched();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule